// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block keeps wall-clock time and a calendar as packed BCD counters: seconds, minutes, hours, a weekday, date, month, year and century. A one-cycle pulse on `tick_1hz` advances the count by one second, and carries ripple upward through the calendar within that same clock edge. Month lengths follow the Gregorian rule: a year ending in 00 is a leap year only when the century is a multiple of four.

Software does not read the running counters directly. It reads a second, visible copy that normally follows the live count on every tick. A freeze bit in the century register stops this copying, so a multi-byte read stays consistent while the live counters keep running. When the freeze is cleared, the next tick reloads every visible byte from the live count in one edge. Host writes set the time by loading the live counter and its visible copy together.

The snapshot control is a three-state machine. `VIEW_TRACK` copies on every tick and moves to `VIEW_FROZEN` when a 1 is written to the freeze bit. `VIEW_FROZEN` copies nothing and moves to `VIEW_RELOAD` when a 0 is written to the freeze bit. `VIEW_RELOAD` moves back to `VIEW_FROZEN` if the freeze bit is written to 1 again. Otherwise, on the next tick it copies all bytes and returns to `VIEW_TRACK`.

Top module: `rtc_dbuf_top`

## Requirements
- R1: After reset, the visible registers read as follows: seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01, year 0x00, century byte 0x20 with the freeze bit at 0. The address map is 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, 7 century.
- R2: Each tick advances the seconds in BCD. Seconds roll 0x59 to 0x00 and carry into minutes, minutes roll 0x59 to 0x00 and carry into hours, and hours roll 0x23 to 0x00. Without a tick or a write, the count does not change.
- R3: At midnight the date rolls to 0x01 after the last day of the month: 31 days, or 30 for months 04, 06, 09 and 11, and February has 28 days or 29 in a leap year. Month 0x12 rolls to 0x01 and carries into the year.
- R4: The year rolls 0x99 to 0x00 and carries into the century. The century byte holds two BCD digits in bits 5:0 and rolls 0x39 to 0x00. A year 0x00 is a leap year only when the century is a multiple of four.
- R5: The weekday advances by one at midnight and wraps from 0x07 to 0x01.
- R6: A host write to addresses 0 to 6, or to the century bits 5:0 at address 7, loads both the live counter and the visible byte, so the new value reads back in the next cycle.
- R7: Writing 1 to bit 6 of address 7 freezes the visible registers. While frozen, they keep the values they held when the freeze was set, and bit 6 reads 1. Bit 7 always reads 0.
- R8: The live count keeps advancing while frozen. The first tick after the freeze bit is written to 0 loads every visible register with the live time.
- R9: Between the write that clears the freeze bit and the next tick, the visible time is unchanged and bit 6 reads 0.
- R10: When a tick and a host write fall in the same cycle, the written register takes the written value. Every other register advances by that tick, with carries computed from the values before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse that advances the time by one second |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 3 | Register address for both read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Visible register at `addr`, combinational |

## Verification
Two functions can fall in the same cycle: a tick and a host write. The bench provokes this by raising `tick_1hz` and `wr_en` in the same cycle. In the first case it writes the minutes while the seconds are at 30. In the second it writes the seconds while they are at 59, which must still carry into the minutes from the old value. Each result is judged against a bench model that advances the untouched fields and installs the written byte.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] date;
        logic [7:0] mon;
        logic [7:0] year;
        logic [7:0] cent;
    } rtc_time_t;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
    localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
    localparam logic [ADDR_W-1:0] A_DOW  = 3'd3;
    localparam logic [ADDR_W-1:0] A_DATE = 3'd4;
    localparam logic [ADDR_W-1:0] A_MON  = 3'd5;
    localparam logic [ADDR_W-1:0] A_YEAR = 3'd6;
    localparam logic [ADDR_W-1:0] A_CENT = 3'd7;
    localparam int FREEZE_BIT = 6;

    localparam rtc_time_t RTC_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                        dow: 8'h01, date: 8'h01, mon: 8'h01,
                                        year: 8'h00, cent: 8'h20};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [6:0] bcd_bin(input logic [7:0] v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    function automatic logic is_leap(input logic [7:0] year, input logic [7:0] cent);
        logic [6:0] yb;
        logic [6:0] cb;
        yb = bcd_bin(year);
        cb = bcd_bin(cent);
        return (yb[1:0] == 2'd0) && ((year != 8'h00) || (cb[1:0] == 2'd0));
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
#(
    parameter logic [7:0] CENT_LAST = 8'h39
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output rtc_time_t         cur,
    output rtc_time_t         nxt
);

    rtc_time_t adv;
    logic c_sec, c_min, c_hr, c_date, c_mon, c_yr;
    logic [7:0] last_day;

    always_comb begin
        last_day = month_last(cur.mon, is_leap(cur.year, cur.cent));
        c_sec  = (cur.sec == 8'h59);
        c_min  = c_sec && (cur.min == 8'h59);
        c_hr   = c_min && (cur.hour == 8'h23);
        c_date = c_hr && (cur.date == last_day);
        c_mon  = c_date && (cur.mon == 8'h12);
        c_yr   = c_mon && (cur.year == 8'h99);

        adv      = cur;
        adv.sec  = c_sec ? 8'h00 : bcd_inc(cur.sec);
        if (c_sec)  adv.min  = (cur.min == 8'h59) ? 8'h00 : bcd_inc(cur.min);
        if (c_min)  adv.hour = (cur.hour == 8'h23) ? 8'h00 : bcd_inc(cur.hour);
        if (c_hr)   adv.dow  = (cur.dow == 8'h07) ? 8'h01 : bcd_inc(cur.dow);
        if (c_hr)   adv.date = c_date ? 8'h01 : bcd_inc(cur.date);
        if (c_date) adv.mon  = c_mon ? 8'h01 : bcd_inc(cur.mon);
        if (c_mon)  adv.year = c_yr ? 8'h00 : bcd_inc(cur.year);
        if (c_yr)   adv.cent = (cur.cent == CENT_LAST) ? 8'h00 : bcd_inc(cur.cent);

        nxt = tick ? adv : cur;
        if (wr_en) begin
            case (wr_addr)
                A_SEC:   nxt.sec  = wr_data;
                A_MIN:   nxt.min  = wr_data;
                A_HOUR:  nxt.hour = wr_data;
                A_DOW:   nxt.dow  = wr_data;
                A_DATE:  nxt.date = wr_data;
                A_MON:   nxt.mon  = wr_data;
                A_YEAR:  nxt.year = wr_data;
                default: nxt.cent = {2'b00, wr_data[5:0]};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur <= RTC_RESET;
        else        cur <= nxt;
    end

    // R2
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && cur.sec == 8'h59) |=> (cur.sec == 8'h00 && cur.min != $past(cur.min)));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(cur));
    // R5
    dow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && cur.dow == 8'h07 && cur.hour == 8'h23 &&
         cur.min == 8'h59 && cur.sec == 8'h59) |=> (cur.dow == 8'h01));

endmodule

// File: rtl/rtc_view_buf.sv
module rtc_view_buf
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  rtc_time_t         live_cur,
    input  rtc_time_t         live_nxt,
    output rtc_time_t         view,
    output logic              frozen
);

    typedef enum logic [1:0] {VIEW_TRACK, VIEW_FROZEN, VIEW_RELOAD} view_state_t;
    view_state_t state, state_nxt;

    logic freeze_wr, freeze_val, copy_en;

    assign freeze_wr  = wr_en && (wr_addr == A_CENT);
    assign freeze_val = wr_data[FREEZE_BIT];
    assign copy_en    = tick && (state != VIEW_FROZEN);
    assign frozen     = (state == VIEW_FROZEN);

    always_comb begin
        state_nxt = state;
        unique case (state)
            VIEW_TRACK:  if (freeze_wr && freeze_val)  state_nxt = VIEW_FROZEN;
            VIEW_FROZEN: if (freeze_wr && !freeze_val) state_nxt = VIEW_RELOAD;
            VIEW_RELOAD: if (freeze_wr && freeze_val)  state_nxt = VIEW_FROZEN;
                         else if (tick)                state_nxt = VIEW_TRACK;
            default:     state_nxt = VIEW_TRACK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= VIEW_TRACK;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            view <= RTC_RESET;
        end else if (copy_en) begin
            view <= live_nxt;
        end else if (wr_en) begin
            case (wr_addr)
                A_SEC:   view.sec  <= wr_data;
                A_MIN:   view.min  <= wr_data;
                A_HOUR:  view.hour <= wr_data;
                A_DOW:   view.dow  <= wr_data;
                A_DATE:  view.date <= wr_data;
                A_MON:   view.mon  <= wr_data;
                A_YEAR:  view.year <= wr_data;
                default: view.cent <= {2'b00, wr_data[5:0]};
            endcase
        end
    end

    // R7
    freeze_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == VIEW_FROZEN && !wr_en) |=> $stable(view));
    // R8
    reload_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state != VIEW_FROZEN && !wr_en) |=> (view == live_cur));
    // R9
    release_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == VIEW_RELOAD && !tick && !wr_en) |=> $stable(view));

endmodule

// File: rtl/rtc_dbuf_top.sv
module rtc_dbuf_top
    import rtc_pkg::*;
#(
    parameter logic [7:0] CENT_LAST = 8'h39
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_1hz,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data
);

    rtc_time_t live_cur, live_nxt, view;
    logic frozen;

    rtc_time_core #(.CENT_LAST(CENT_LAST)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .wr_en(wr_en),
        .wr_addr(addr), .wr_data(wr_data), .cur(live_cur), .nxt(live_nxt)
    );

    rtc_view_buf u_view (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .wr_en(wr_en),
        .wr_addr(addr), .wr_data(wr_data), .live_cur(live_cur),
        .live_nxt(live_nxt), .view(view), .frozen(frozen)
    );

    always_comb begin
        case (addr)
            A_SEC:   rd_data = view.sec;
            A_MIN:   rd_data = view.min;
            A_HOUR:  rd_data = view.hour;
            A_DOW:   rd_data = view.dow;
            A_DATE:  rd_data = view.date;
            A_MON:   rd_data = view.mon;
            A_YEAR:  rd_data = view.year;
            default: rd_data = {1'b0, frozen, view.cent[5:0]};
        endcase
    end

    // R7
    cent_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_CENT) |-> (rd_data[7] == 1'b0));

endmodule

// File: tb/tb_rtc_dbuf_top.sv
module tb_rtc_dbuf_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;

    int s, mi, h, w, d, mo, y, c;

    rtc_dbuf_top dut (.clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
                      .addr(addr), .wr_data(wr_data), .rd_data(rd_data));

    always #2 clk = ~clk;

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic bit leap_of(input int yy, input int cc);
        return (yy % 4 == 0) && (yy != 0 || cc % 4 == 0);
    endfunction

    function automatic int days_of(input int m, input int yy, input int cc);
        if (m == 2) return leap_of(yy, cc) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic model_tick();
        s++;
        if (s == 60) begin
            s = 0; mi++;
            if (mi == 60) begin
                mi = 0; h++;
                if (h == 24) begin
                    h = 0;
                    w = (w == 7) ? 1 : w + 1;
                    d++;
                    if (d > days_of(mo, y, c)) begin
                        d = 1; mo++;
                        if (mo == 13) begin
                            mo = 1; y++;
                            if (y == 100) begin
                                y = 0;
                                c = (c == 39) ? 0 : c + 1;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] got,
                       input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick_once();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic check_time(input string req);
        logic [7:0] v;
        rd(3'd0, v); chk(req, "sec",  v, to_bcd(s));
        rd(3'd1, v); chk(req, "min",  v, to_bcd(mi));
        rd(3'd2, v); chk(req, "hour", v, to_bcd(h));
    endtask

    task automatic check_all(input string req);
        logic [7:0] v;
        check_time(req);
        rd(3'd3, v); chk(req, "dow",  v, to_bcd(w));
        rd(3'd4, v); chk(req, "date", v, to_bcd(d));
        rd(3'd5, v); chk(req, "mon",  v, to_bcd(mo));
        rd(3'd6, v); chk(req, "year", v, to_bcd(y));
        rd(3'd7, v); chk(req, "cent", v, to_bcd(c));
    endtask

    task automatic set_all(input int ss, input int mm, input int hh, input int ww,
                           input int dd, input int mon, input int yy, input int cc);
        wr(3'd7, to_bcd(cc)); wr(3'd6, to_bcd(yy)); wr(3'd5, to_bcd(mon));
        wr(3'd4, to_bcd(dd)); wr(3'd3, to_bcd(ww)); wr(3'd2, to_bcd(hh));
        wr(3'd1, to_bcd(mm)); wr(3'd0, to_bcd(ss));
        s = ss; mi = mm; h = hh; w = ww; d = dd; mo = mon; y = yy; c = cc;
    endtask

    bit finished = 1'b0;

    initial begin
        #(4 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int cy[6];
        int yr[6];
        cy = '{20, 20, 20, 21, 19, 39};
        yr = '{23, 24, 0, 0, 99, 99};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        s = 0; mi = 0; h = 0; w = 1; d = 1; mo = 1; y = 0; c = 20;
        check_all("R1");

        // R6 write and read back of every register
        set_all(17, 42, 9, 3, 15, 6, 31, 20);
        check_all("R6");

        // R2 idle cycles change nothing
        repeat (20) @(negedge clk);
        check_all("R2");

        // R2 one-hour sweep
        set_all(0, 0, 10, 2, 10, 3, 25, 20);
        for (int i = 0; i < 3600; i++) begin
            tick_once();
            model_tick();
            check_time("R2");
        end
        // R2 R5 midnight with weekday wrap
        set_all(59, 59, 23, 7, 10, 3, 25, 20);
        tick_once(); model_tick();
        check_all("R5");

        // R3 R4 month ends over several years, including leap rules
        for (int k = 0; k < 6; k++) begin
            for (int m = 1; m <= 12; m++) begin
                set_all(59, 59, 23, (m % 7) + 1, days_of(m, yr[k], cy[k]), m, yr[k], cy[k]);
                tick_once(); model_tick();
                check_all((m == 12) ? "R4" : "R3");
            end
            // R3 February day 28 goes to 29 only in a leap year
            set_all(59, 59, 23, 1, 28, 2, yr[k], cy[k]);
            tick_once(); model_tick();
            check_all("R3");
        end

        // R7 freeze keeps the snapshot while ticks arrive
        set_all(0, 0, 12, 4, 5, 8, 26, 20);
        wr(3'd7, 8'h40 | to_bcd(20));
        rd(3'd7, v); chk("R7", "freeze bit set", v, 8'h40 | to_bcd(20));
        for (int i = 0; i < 5; i++) begin
            tick_once();
            check_time("R7");
        end
        // R9 release write does not refresh yet
        wr(3'd7, to_bcd(20));
        rd(3'd7, v); chk("R9", "freeze bit clear", v, to_bcd(20));
        repeat (4) @(negedge clk);
        check_time("R9");
        // R8 next tick loads the live count: five ticks passed under freeze, one now
        tick_once();
        for (int i = 0; i < 6; i++) model_tick();
        check_all("R8");
        tick_once(); model_tick();
        check_all("R8");

        // R10 tick and minute write in the same cycle
        set_all(30, 10, 14, 2, 9, 9, 27, 20);
        @(negedge clk);
        tick_1hz = 1'b1; wr_en = 1'b1; addr = 3'd1; wr_data = 8'h45;
        @(negedge clk);
        tick_1hz = 1'b0; wr_en = 1'b0;
        s = 31; mi = 45;
        check_all("R10");
        // R10 tick and seconds write at 59: minutes carry from the old seconds
        set_all(59, 10, 14, 2, 9, 9, 27, 20);
        @(negedge clk);
        tick_1hz = 1'b1; wr_en = 1'b1; addr = 3'd0; wr_data = 8'h05;
        @(negedge clk);
        tick_1hz = 1'b0; wr_en = 1'b0;
        s = 5; mi = 11;
        check_all("R10");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule